// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with System-Reset Pin Override

This block is a test access port controller for boundary-scan board testing. A serial test clock and mode-select line walk a sixteen-state controller. The controller moves bits between a serial data input and a serial data output. The data path runs through one of four registers: an 8-bit instruction register, a 1-bit bypass register, a 32-bit identification register, or a boundary chain. The boundary chain has three cells for each pin: an input capture cell, an output data cell and an output enable cell.

The boundary update latches can take over the pins from the core. This happens under the external-test instruction and the clamp instruction. The float instruction disables every output enable. A separate active-low system reset has the last word over a parameterised group of bus pins. While that reset is low, the output enables of those pins are held off, whatever the instruction or the latch contents say. The port meets boundary-scan rules only while the system reset is high.

The core connects its outputs and enables through the block and receives the pad values unchanged. The test clock domain is reset by an optional asynchronous test reset, or by holding the mode-select line high.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The controller state advances on each rising test clock edge as a function of the mode-select line over the sixteen standard states. Five consecutive rising edges with mode-select high reach Test-Logic-Reset from any state.
- R2: Entering Test-Logic-Reset, by mode-select or by driving `trst_n` low, selects the identification instruction (02h) and returns every pin to functional mode (`pin_out = core_out`, `pin_oe = core_oe`, subject to R11).
- R3: The instruction register is 8 bits, shifted least significant bit first. In Capture-IR it loads 8'b0000_0001, which then appears first on `tdo`.
- R4: Opcodes are 00h external test, 01h sample/preload, 02h identification, 03h clamp, 04h float and FFh bypass. Every other opcode behaves as bypass: the data path is the 1-bit bypass register and the pins stay in functional mode.
- R5: The bypass register captures 0 in Capture-DR, so a data scan of n bits returns 0 followed by the first n-1 input bits.
- R6: The identification register is 32 bits and is shifted least significant bit first. It holds the IDCODE parameter with bit 0 forced to 1.
- R7: The boundary chain has 3*PINS cells, with cell 0 nearest `tdo`. For pin i, cell 3i captures `pad_in[i]`, cell 3i+1 captures `core_out[i]` and cell 3i+2 captures `core_oe[i]`. Capture happens under external test and sample/preload. Update-DR copies the chain into the update latches.
- R8: Under external test, `pin_out[i]` and `pin_oe[i]` come from latch cells 3i+1 and 3i+2. Under sample/preload the pins stay functional.
- R9: Under clamp, the pins come from the update latches and the data path is the bypass register.
- R10: Under float, every `pin_oe` is 0, `pin_out` follows `core_out`, and the data path is the bypass register.
- R11: While `sys_rst_n` is low, `pin_oe[i]` is 0 for every pin whose bit is set in BUS_MASK. This holds in every mode. Pins outside the mask are unaffected.
- R12: `tdo` and `tdo_en` change only on the falling test clock edge. `tdo_en` is high only after Shift-IR or Shift-DR has been entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for `tdo` |
| sys_rst_n | input | 1 | System reset, active low; floats the bus pin group |
| core_out | input | PINS | Core output values |
| core_oe | input | PINS | Core output enables |
| pad_in | input | PINS | Values seen at the pads |
| pin_out | output | PINS | Output values to the pads |
| pin_oe | output | PINS | Output enables to the pads |

## Verification
Every opcode outside the six defined ones is loaded in turn. A decoder that let such a code reach the boundary chain or the pin drivers would lengthen the scan or move the pins. All 256 combinations of latched outputs and enables are driven under external test, and each is checked with the system reset both high and low. A cell ordered wrongly, or an override that leaked into the pins outside the mask, would show as a pin mismatch. Reset is entered from the middle of an instruction shift and also through the asynchronous test reset. A controller that failed to drop the instruction would leave the pins driven from the latches. On every clock, `tdo` is compared across the rising edge, which catches an output register placed on the wrong edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'h02;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'h03;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h04;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

  typedef enum logic [1:0] {PM_FUNC, PM_DRIVE, PM_FLOAT} pin_mode_e;
  typedef enum logic [1:0] {DS_BYPASS, DS_IDCODE, DS_BOUNDARY} dr_sel_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= TS_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R1: mode-select high keeps the controller in reset
  a_r1_reset_sticky: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == TS_RESET && tms) |=> (state_q == TS_RESET));
  // R1: capture with mode-select low enters shift
  a_r1_capture_to_shift: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == TS_CAP_DR && !tms) |=> (state_q == TS_SHIFT_DR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_bit,
  output dr_sel_e    dr_sel,
  output pin_mode_e  pin_mode
);

  logic [IR_W-1:0] shift_q, shift_d;
  logic [IR_W-1:0] instr_q, instr_d;

  always_comb begin
    shift_d = shift_q;
    if (state == TS_CAP_IR)        shift_d = {{(IR_W-2){1'b0}}, 2'b01};
    else if (state == TS_SHIFT_IR) shift_d = {tdi, shift_q[IR_W-1:1]};
  end

  always_comb begin
    instr_d = instr_q;
    if (state == TS_RESET)       instr_d = OP_IDCODE;
    else if (state == TS_UPD_IR) instr_d = shift_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      instr_q <= OP_IDCODE;
    end else begin
      shift_q <= shift_d;
      instr_q <= instr_d;
    end
  end

  always_comb begin
    dr_sel   = DS_BYPASS;
    pin_mode = PM_FUNC;
    unique case (instr_q)
      OP_EXTEST: begin dr_sel = DS_BOUNDARY; pin_mode = PM_DRIVE; end
      OP_SAMPLE: dr_sel = DS_BOUNDARY;
      OP_IDCODE: dr_sel = DS_IDCODE;
      OP_CLAMP:  pin_mode = PM_DRIVE;
      OP_HIGHZ:  pin_mode = PM_FLOAT;
      default:   ;
    endcase
  end

  assign ir_bit = shift_q[0];

  // R2: reset state yields the identification path and functional pins
  a_r2_reset_selects_id: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> (dr_sel == DS_IDCODE && pin_mode == PM_FUNC));
  // R3: capture pattern puts a 1 at the serial output end
  a_r3_capture_ir: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (ir_bit == 1'b1));
  // R10: float opcode selects bypass and floats pins
  a_r10_float_decode: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_UPD_IR && shift_q == OP_HIGHZ) |=> (pin_mode == PM_FLOAT && dr_sel == DS_BYPASS));

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import scan_tap_pkg::*;
#(
  parameter int PINS = 4
)(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  logic            sel,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] core_out,
  input  logic [PINS-1:0] core_oe,
  output logic            bsr_bit,
  output logic [PINS-1:0] upd_out,
  output logic [PINS-1:0] upd_oe
);

  localparam int LEN = 3 * PINS;

  logic [LEN-1:0] chain_q, chain_d;
  logic [LEN-1:0] latch_q, latch_d;
  logic [LEN-1:0] cap_vec;

  for (genvar i = 0; i < PINS; i++) begin : g_cell
    assign cap_vec[3*i]   = pad_in[i];
    assign cap_vec[3*i+1] = core_out[i];
    assign cap_vec[3*i+2] = core_oe[i];
    assign upd_out[i]     = latch_q[3*i+1];
    assign upd_oe[i]      = latch_q[3*i+2];
  end

  always_comb begin
    chain_d = chain_q;
    if (sel && state == TS_CAP_DR)        chain_d = cap_vec;
    else if (sel && state == TS_SHIFT_DR) chain_d = {tdi, chain_q[LEN-1:1]};
  end

  always_comb begin
    latch_d = latch_q;
    if (sel && state == TS_UPD_DR) latch_d = chain_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      latch_q <= '0;
    end else begin
      chain_q <= chain_d;
      latch_q <= latch_d;
    end
  end

  assign bsr_bit = chain_q[0];

  // R7: cell 0 holds the pad value of pin 0 after capture
  a_r7_capture_pad0: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && state == TS_CAP_DR) |=> (bsr_bit == $past(pad_in[0])));
  // R7: latched output of pin 0 only moves at update
  a_r7_latch_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !(sel && state == TS_UPD_DR) |=> $stable(upd_out[0]));

endmodule

// File: rtl/tap_pin_mux.sv
module tap_pin_mux
  import scan_tap_pkg::*;
#(
  parameter int              PINS     = 4,
  parameter logic [PINS-1:0] BUS_MASK = '1
)(
  input  pin_mode_e       pin_mode,
  input  logic            sys_rst_n,
  input  logic [PINS-1:0] core_out,
  input  logic [PINS-1:0] core_oe,
  input  logic [PINS-1:0] upd_out,
  input  logic [PINS-1:0] upd_oe,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic oe_sel;
    logic force_off;

    assign force_off = BUS_MASK[i] && !sys_rst_n;

    always_comb begin
      unique case (pin_mode)
        PM_DRIVE: begin pin_out[i] = upd_out[i];  oe_sel = upd_oe[i]; end
        PM_FLOAT: begin pin_out[i] = core_out[i]; oe_sel = 1'b0;      end
        default:  begin pin_out[i] = core_out[i]; oe_sel = core_oe[i]; end
      endcase
    end

    assign pin_oe[i] = oe_sel && !force_off;
  end

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int              PINS     = 4,
  parameter logic [PINS-1:0] BUS_MASK = 4'b1100,
  parameter logic [31:0]     IDCODE   = 32'h0BAD_C0DE
)(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  input  logic            sys_rst_n,
  input  logic [PINS-1:0] core_out,
  input  logic [PINS-1:0] core_oe,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);

  localparam logic [31:0] ID_VAL = IDCODE | 32'h1;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tap_state_e state;
  logic       ir_bit, bsr_bit;
  dr_sel_e    dr_sel;
  pin_mode_e  pin_mode;
  logic [PINS-1:0] upd_out, upd_oe;

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .ir_bit(ir_bit), .dr_sel(dr_sel), .pin_mode(pin_mode)
  );

  tap_bsr #(.PINS(PINS)) u_bsr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .sel(dr_sel == DS_BOUNDARY),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .bsr_bit(bsr_bit), .upd_out(upd_out), .upd_oe(upd_oe)
  );

  tap_pin_mux #(.PINS(PINS), .BUS_MASK(BUS_MASK)) u_mux (
    .pin_mode(pin_mode), .sys_rst_n(sys_rst_n),
    .core_out(core_out), .core_oe(core_oe),
    .upd_out(upd_out), .upd_oe(upd_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // bypass and identification registers
  logic        byp_q, byp_d;
  logic [31:0] id_q, id_d;

  always_comb begin
    byp_d = byp_q;
    id_d  = id_q;
    if (state == TS_CAP_DR) begin
      if (dr_sel == DS_BYPASS) byp_d = 1'b0;
      if (dr_sel == DS_IDCODE) id_d  = ID_VAL;
    end else if (state == TS_SHIFT_DR) begin
      if (dr_sel == DS_BYPASS) byp_d = tdi;
      if (dr_sel == DS_IDCODE) id_d  = {tdi, id_q[31:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      byp_q <= byp_d;
      id_q  <= id_d;
    end
  end

  // serial output, launched on the falling edge
  logic dr_bit, tdo_d, en_d;

  always_comb begin
    unique case (dr_sel)
      DS_BOUNDARY: dr_bit = bsr_bit;
      DS_IDCODE:   dr_bit = id_q[0];
      default:     dr_bit = byp_q;
    endcase
    tdo_d = (state == TS_SHIFT_IR) ? ir_bit : dr_bit;
    en_d  = (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= en_d;
    end
  end

  // R12: output enable only while a shift state is current
  a_r12_en_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == TS_SHIFT_IR || state == TS_SHIFT_DR));
  // R11: system reset floats the bus group
  a_r11_bus_float: assert property (@(posedge tck) disable iff (!rst_n)
    !sys_rst_n |-> ((pin_oe & BUS_MASK) == '0));
  // R10: float mode leaves no pin enabled
  a_r10_all_float: assert property (@(posedge tck) disable iff (!rst_n)
    (pin_mode == PM_FLOAT) |-> (pin_oe == '0));
  // R5: bypass captures zero
  a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_DR && dr_sel == DS_BYPASS) |=> (byp_q == 1'b0));

endmodule

// File: tb/scan_tap_ctrl_bench.sv
`timescale 1ns/100ps
module scan_tap_ctrl_bench;

  localparam int          PINS = 4;
  localparam logic [3:0]  MASK = 4'b1100;
  localparam logic [31:0] IDV  = 32'h0BAD_C0DF;

  logic tck = 1'b0;
  logic trst_n, tms, tdi, sys_rst_n;
  logic tdo, tdo_en;
  logic [PINS-1:0] core_out, core_oe, pad_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  int edge_viol = 0;
  int en_bad = 0;
  int mode = 0;               // 0 functional, 1 drive from latches, 2 float
  logic [11:0] lat = '0;      // bench model of update latches

  always #2 tck = ~tck;

  scan_tap_ctrl #(.PINS(PINS), .BUS_MASK(MASK), .IDCODE(32'h0BAD_C0DE)) u_scan_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .sys_rst_n(sys_rst_n), .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d, output logic o);
    tms = t; tdi = d; o = tdo;
    @(posedge tck); #0.5;
    if (tdo !== o) edge_viol++;
    @(negedge tck); #1;
  endtask

  task automatic to_idle();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 8; i++) begin
      if (tdo_en !== 1'b1) en_bad++;
      step(i == 7, op[i], o); cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    if (tdo_en !== 1'b0) en_bad++;
    case (op)
      8'h00, 8'h03: mode = 1;
      8'h04:        mode = 2;
      default:      mode = 0;
    endcase
  endtask

  task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      if (tdo_en !== 1'b1) en_bad++;
      step(i == len - 1, din[i], o); dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    if (tdo_en !== 1'b0) en_bad++;
  endtask

  function automatic logic [7:0] exp_pins(int m, logic [11:0] l, logic sr);
    logic [3:0] o, e;
    for (int i = 0; i < PINS; i++) begin
      case (m)
        1:       begin o[i] = l[3*i+1]; e[i] = l[3*i+2]; end
        2:       begin o[i] = core_out[i]; e[i] = 1'b0; end
        default: begin o[i] = core_out[i]; e[i] = core_oe[i]; end
      endcase
      if (!sr && MASK[i]) e[i] = 1'b0;
    end
    return {o, e};
  endfunction

  function automatic logic [11:0] cap_vec();
    logic [11:0] c;
    for (int i = 0; i < PINS; i++) begin
      c[3*i] = pad_in[i]; c[3*i+1] = core_out[i]; c[3*i+2] = core_oe[i];
    end
    return c;
  endfunction

  task automatic chk_pins(input string req);
    logic [7:0] e;
    e = exp_pins(mode, lat, sys_rst_n);
    chk({pin_out, pin_oe} === e, req, {pin_out, pin_oe}, e);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  ic;
    logic [63:0] dout;
    logic [11:0] d;
    logic        o;

    trst_n = 0; tms = 1; tdi = 0; sys_rst_n = 1;
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b0011;
    @(negedge tck); #1;
    repeat (3) @(negedge tck); #1;
    // reset state: functional pins, no output enable
    chk_pins("R2 reset pins");
    chk(tdo_en === 1'b0, "R12 reset tdo_en", tdo_en, 0);
    trst_n = 1;
    step(1, 0, o); step(1, 0, o); step(1, 0, o); step(0, 0, o);

    // R6 R2: identification path right after reset
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === IDV, "R6 idcode after reset", dout[31:0], IDV);

    // R3: capture pattern of instruction register
    scan_ir(8'hFF, ic);
    chk(ic === 8'h01, "R3 capture-ir", ic, 8'h01);

    // R5 R4: bypass delays one bit, first bit zero
    scan_dr(16, 64'hB4C3, dout);
    chk(dout[15:0] === {16'hB4C3 << 1}, "R5 bypass", dout[15:0], 16'hB4C3 << 1);

    // R4: every undefined opcode acts as bypass with functional pins
    for (int op = 5; op < 255; op++) begin
      scan_ir(op[7:0], ic);
      scan_dr(4, 64'hB, dout);
      chk(dout[3:0] === 4'b0110, "R4 undefined opcode bypass", dout[3:0], 4'b0110);
      chk_pins("R4 undefined opcode pins");
    end

    // R7 R8: sample/preload captures and preloads, pins stay functional
    scan_ir(8'h01, ic);
    pad_in = 4'b1001; core_out = 4'b0101; core_oe = 4'b1110;
    d = 12'h5A3;
    scan_dr(12, {52'h0, d}, dout);
    chk(dout[11:0] === cap_vec(), "R7 sample capture", dout[11:0], cap_vec());
    lat = d;
    chk_pins("R8 sample functional");

    // R8: drive pins from preloaded latches
    scan_ir(8'h00, ic);
    chk_pins("R8 extest preload drive");

    // R7 R8 R11: full sweep of latched out/oe under external test
    for (int v = 0; v < 256; v++) begin
      logic [11:0] c;
      pad_in = v[3:0] ^ 4'h5; core_out = ~v[3:0]; core_oe = v[7:4] ^ 4'h3;
      for (int i = 0; i < PINS; i++) begin
        d[3*i] = ~v[i]; d[3*i+1] = v[i]; d[3*i+2] = v[4+i];
      end
      c = cap_vec();
      scan_dr(12, {52'h0, d}, dout);
      chk(dout[11:0] === c, "R7 extest capture", dout[11:0], c);
      lat = d;
      sys_rst_n = 1; #0.2;
      chk_pins("R8 extest drive");
      sys_rst_n = 0; #0.2;
      chk_pins("R11 extest bus float");
      sys_rst_n = 1; #0.2;
    end

    // R9: clamp drives from latches with bypass path
    scan_ir(8'h03, ic);
    chk_pins("R9 clamp pins");
    scan_dr(8, 64'h96, dout);
    chk(dout[7:0] === 8'h2C, "R9 clamp bypass", dout[7:0], 8'h2C);
    chk_pins("R9 clamp pins after scan");
    sys_rst_n = 0; #0.2;
    chk_pins("R11 clamp bus float");
    sys_rst_n = 1; #0.2;

    // R10: float all outputs with bypass path
    core_oe = 4'hF;
    scan_ir(8'h04, ic);
    chk_pins("R10 highz pins");
    scan_dr(8, 64'h5B, dout);
    chk(dout[7:0] === 8'hB6, "R10 highz bypass", dout[7:0], 8'hB6);

    // R11: functional mode override, outside mask untouched
    scan_ir(8'hFF, ic);
    sys_rst_n = 0; #0.2;
    chk_pins("R11 functional bus float");
    sys_rst_n = 1; #0.2;

    // R1 R2: five mode-select highs from inside an instruction shift
    scan_ir(8'h00, ic);
    chk_pins("R8 extest reentry");
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o); step(0, 1, o);
    to_idle();
    mode = 0;
    chk_pins("R1 tms reset pins functional");
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === IDV, "R2 idcode after tms reset", dout[31:0], IDV);

    // R2: asynchronous test reset during external test
    scan_ir(8'h00, ic);
    chk_pins("R8 extest before trst");
    trst_n = 0; #0.5;
    mode = 0;
    chk_pins("R2 trst pins functional");
    @(negedge tck); #1;
    trst_n = 1;
    step(1, 0, o); step(1, 0, o); step(0, 0, o);
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === IDV, "R2 idcode after trst", dout[31:0], IDV);

    // R12: edge and enable discipline over the whole run
    chk(edge_viol == 0, "R12 tdo moved on rising edge", edge_viol, 0);
    chk(en_bad == 0, "R12 tdo_en outside shift", en_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule